// File: doc/BRIEF.md
# Codec power-down sequencing controller

This block decides when the digital core of a telephony PCM codec is awake. It runs on a free-running reference clock and watches three inputs. The first is a dual-purpose pin that carries either a master clock or a static level. The other two are the transmit and receive frame sync inputs. It drives two outputs. `core_on` enables the analog sections. `pcm_drive_en` allows the serial PCM data output to leave high impedance.

The core wakes on a frame sync rising edge when the dual-purpose pin permits it. The pin permits wake-up when it is static low or toggling. The core sleeps when the pin rests high. It also sleeps after a programmable number of reference cycles without any frame sync rising edge. After each wake-up the data output stays released-off until the second transmit sync edge of that awake period. The transmit sync edge that caused the wake-up counts as the first one.

All three inputs go through two-flop synchronisers before edge detection. The pin is classified once per fixed window of reference cycles. It is "clocked" when it shows two or more edges in the window. Otherwise it is "static" at its sampled level.

Top module: `codec_pwr_seq`

## Requirements
- R1: During and after synchronous reset, `core_on` = 0 and `pcm_drive_en` = 0. This holds until a wake-up condition occurs.
- R2: `core_on` goes to 1 only on a rising edge of `tx_sync` or `rx_sync` while the pin permits it. A permitting pin with no sync edge leaves `core_on` at 0.
- R3: A pin that rests high for a full classification window of `PIN_WIN` cycles forces `core_on` = 0 within two windows plus synchroniser delay. Sync edges do not wake the core while the pin is classified static high.
- R4: A pin toggling with two or more edges per window permits wake-up, whatever its level. A pin held static low also permits wake-up.
- R5: With the core on and no sync rising edge on either input, `core_on` returns to 0 about `IDLE_CYCLES` reference cycles after the last edge.
- R6: Any rising edge of `tx_sync` or `rx_sync` reloads the idle timer. Edges spaced closer than `IDLE_CYCLES` keep the core on indefinitely.
- R7: `pcm_drive_en` = 1 only while `core_on` = 1 and at least two `tx_sync` rising edges have been seen since that wake-up. The waking edge counts. `rx_sync` edges do not count.
- R8: Every return to sleep clears the transmit sync count. After the next wake-up, a single `tx_sync` edge leaves `pcm_drive_en` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| clkpd_in | input | 1 | Dual-purpose pin: master clock, or static level (high = sleep) |
| tx_sync | input | 1 | Transmit frame sync, asynchronous |
| rx_sync | input | 1 | Receive frame sync, asynchronous |
| core_on | output | 1 | Core awake; enables analog sections |
| pcm_drive_en | output | 1 | 1 allows the PCM data output to drive, 0 holds it high impedance |

## Verification
The wake logic is tried with the pin static low, static high and toggling. It is combined with zero to three transmit sync pulses and zero or one receive pulse. This separates the pin classes from each other and from the effect of sync pulses, and shows whether the receive edge is wrongly counted for output release. Directed sequences let the idle timer expire, and keep it alive with pulses spaced below the timeout, to tell expiry apart from reload. Other sequences drive the pin high, or stop a running clock at high, while the core is awake. The last re-wakes the core after sleep with a single transmit pulse, to show that the count was cleared.

// File: rtl/codec_pwr_pkg.sv
package codec_pwr_pkg;
  typedef enum logic {PWR_DOWN = 1'b0, PWR_UP = 1'b1} pwr_state_e;

  localparam int unsigned TX_SYNCS_TO_DRIVE = 2;
  typedef logic [1:0] sync_cnt_t;

  function automatic sync_cnt_t sat_inc(sync_cnt_t v);
    return (v >= sync_cnt_t'(TX_SYNCS_TO_DRIVE)) ? v : v + 1'b1;
  endfunction
endpackage

// File: rtl/cps_sync.sv
module cps_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/cps_pin_class.sv
module cps_pin_class #(
  parameter int unsigned WIN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_s,
  output logic static_hi
);
  localparam int unsigned WW = (WIN > 1) ? $clog2(WIN) : 1;

  logic          pin_prev;
  logic [WW-1:0] win_cnt;
  logic [1:0]    edges;
  logic          edge_now, win_last, enough;

  assign edge_now = pin_s ^ pin_prev;
  assign win_last = (win_cnt == WW'(WIN - 1));
  assign enough   = (edges >= 2'd2) || (edges == 2'd1 && edge_now);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_prev  <= 1'b0;
      win_cnt   <= '0;
      edges     <= '0;
      static_hi <= 1'b1;
    end else begin
      pin_prev <= pin_s;
      if (win_last) begin
        win_cnt   <= '0;
        edges     <= '0;
        static_hi <= !enough && pin_s;
      end else begin
        win_cnt <= win_cnt + 1'b1;
        if (edge_now && edges != 2'd2) edges <= edges + 1'b1;
      end
    end
  end

  // R4: the class is re-decided only at a window boundary
  assert_class_at_window_end_R4: assert property (@(posedge clk) disable iff (rst)
    !win_last |=> $stable(static_hi));
endmodule

// File: rtl/cps_idle_timer.sv
module cps_idle_timer #(
  parameter int unsigned TIMEOUT = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic reload,
  output logic idle
);
  localparam int unsigned TW = $clog2(TIMEOUT + 1);

  logic [TW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst)                count_q <= '0;
    else if (reload)        count_q <= TW'(TIMEOUT);
    else if (count_q != '0) count_q <= count_q - 1'b1;
  end

  assign idle = (count_q == '0);

  assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
    reload |=> count_q == TW'(TIMEOUT));

  assert_count_down_R5: assert property (@(posedge clk) disable iff (rst)
    (!reload && count_q != '0) |=> count_q == $past(count_q) - 1'b1);
endmodule

// File: rtl/codec_pwr_seq.sv
module codec_pwr_seq
  import codec_pwr_pkg::*;
#(
  parameter int unsigned PIN_WIN     = 16,
  parameter int unsigned IDLE_CYCLES = 250000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clkpd_in,
  input  logic tx_sync,
  input  logic rx_sync,
  output logic core_on,
  output logic pcm_drive_en
);
  logic [2:0] raw_in, syn;
  logic       pin_s, tx_s, rx_s;
  logic       tx_prev, rx_prev;
  logic       tx_edge, rx_edge, any_edge;
  logic       pin_static_hi, timer_idle;
  pwr_state_e state_q, state_d;
  sync_cnt_t  txcnt_q, txcnt_d;

  assign raw_in = {clkpd_in, tx_sync, rx_sync};

  cps_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(syn)
  );

  assign {pin_s, tx_s, rx_s} = syn;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_prev <= 1'b0;
      rx_prev <= 1'b0;
    end else begin
      tx_prev <= tx_s;
      rx_prev <= rx_s;
    end
  end

  assign tx_edge  = tx_s & ~tx_prev;
  assign rx_edge  = rx_s & ~rx_prev;
  assign any_edge = tx_edge | rx_edge;

  cps_pin_class #(.WIN(PIN_WIN)) u_pin (
    .clk(clk), .rst(rst), .pin_s(pin_s), .static_hi(pin_static_hi)
  );

  cps_idle_timer #(.TIMEOUT(IDLE_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .reload(any_edge), .idle(timer_idle)
  );

  always_comb begin
    state_d = state_q;
    if (pin_static_hi)   state_d = PWR_DOWN;
    else if (any_edge)   state_d = PWR_UP;
    else if (timer_idle) state_d = PWR_DOWN;

    if (state_d == PWR_DOWN) txcnt_d = '0;
    else if (tx_edge)        txcnt_d = sat_inc(txcnt_q);
    else                     txcnt_d = txcnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= PWR_DOWN;
      txcnt_q      <= '0;
      pcm_drive_en <= 1'b0;
    end else begin
      state_q      <= state_d;
      txcnt_q      <= txcnt_d;
      pcm_drive_en <= (state_d == PWR_UP) &&
                      (txcnt_d >= sync_cnt_t'(TX_SYNCS_TO_DRIVE));
    end
  end

  assign core_on = (state_q == PWR_UP);

  assert_static_high_down_R3: assert property (@(posedge clk) disable iff (rst)
    pin_static_hi |=> !core_on);

  assert_wake_needs_sync_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(core_on) |-> $past(any_edge));

  assert_idle_down_R5: assert property (@(posedge clk) disable iff (rst)
    (timer_idle && !any_edge) |=> !core_on);

  assert_drive_needs_up_R7: assert property (@(posedge clk) disable iff (rst)
    pcm_drive_en |-> core_on);

  assert_count_cleared_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(core_on) && !$past(tx_edge)) |-> !pcm_drive_en);
endmodule

// File: tb/codec_pwr_seq_test.sv
module codec_pwr_seq_test;
  localparam int unsigned PIN_WIN = 16;
  localparam int unsigned IDLE    = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clkpd_in = 1'b0;
  logic tx_sync = 1'b0;
  logic rx_sync = 1'b0;
  logic core_on, pcm_drive_en;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  int pin_mode = 0; // 0 static low, 1 static high, 2 toggling

  always #2 clk = ~clk;

  codec_pwr_seq #(.PIN_WIN(PIN_WIN), .IDLE_CYCLES(IDLE), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .clkpd_in(clkpd_in), .tx_sync(tx_sync),
    .rx_sync(rx_sync), .core_on(core_on), .pcm_drive_en(pcm_drive_en)
  );

  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph++;
      if (pin_mode == 2) begin
        if (ph % 4 == 0) clkpd_in = ~clkpd_in;
      end else begin
        clkpd_in = (pin_mode == 1);
      end
    end
  end

  // {mode[7:6], ntx[5:4], nrx[3:2], exp_up[1], exp_drive[0]}
  localparam logic [7:0] VEC [9] = '{
    8'b00_00_00_00, 8'b00_01_00_10, 8'b00_10_00_11,
    8'b00_00_01_10, 8'b00_01_01_10, 8'b01_10_01_00,
    8'b10_10_00_11, 8'b10_00_01_10, 8'b00_11_00_11
  };

  task automatic check(string tag, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tx();
    @(negedge clk); tx_sync = 1'b1; wait_n(3); tx_sync = 1'b0; wait_n(6);
  endtask

  task automatic pulse_rx();
    @(negedge clk); rx_sync = 1'b1; wait_n(3); rx_sync = 1'b0; wait_n(6);
  endtask

  task automatic do_reset(int mode);
    @(negedge clk); rst = 1'b1; pin_mode = mode; wait_n(3); rst = 1'b0;
    wait_n(3 * PIN_WIN);
  endtask

  initial begin
    wait_n(2);
    check("R1 reset core_on", core_on, 1'b0);
    check("R1 reset pcm_drive_en", pcm_drive_en, 1'b0);
    rst = 1'b0;
    wait_n(3 * PIN_WIN);
    check("R1 idle after reset core_on", core_on, 1'b0);
    check("R1 idle after reset pcm_drive_en", pcm_drive_en, 1'b0);

    // R2/R3/R4/R7 vector table
    for (int v = 0; v < 9; v++) begin
      do_reset(int'(VEC[v][7:6]));
      for (int k = 0; k < int'(VEC[v][3:2]); k++) pulse_rx();
      for (int k = 0; k < int'(VEC[v][5:4]); k++) pulse_tx();
      check($sformatf("vector %0d core_on (R2/R3/R4)", v), core_on, VEC[v][1]);
      check($sformatf("vector %0d pcm_drive_en (R7)", v), pcm_drive_en, VEC[v][0]);
    end

    // R5 timeout, then R8 count cleared on re-wake
    do_reset(0);
    pulse_tx(); pulse_tx();
    check("R7 two tx drive", pcm_drive_en, 1'b1);
    wait_n(190);
    check("R5 before timeout core_on", core_on, 1'b1);
    wait_n(120);
    check("R5 after timeout core_on", core_on, 1'b0);
    check("R5 after timeout pcm_drive_en", pcm_drive_en, 1'b0);
    pulse_tx();
    check("R8 re-wake core_on", core_on, 1'b1);
    check("R8 one tx after re-wake", pcm_drive_en, 1'b0);
    pulse_tx();
    check("R8 second tx after re-wake", pcm_drive_en, 1'b1);

    // R6 reload by spaced rx edges
    do_reset(0);
    for (int k = 0; k < 4; k++) begin
      pulse_rx();
      wait_n(140);
    end
    check("R6 kept awake by reloads", core_on, 1'b1);
    wait_n(200);
    check("R6 down after last reload", core_on, 1'b0);

    // R3 static high while awake
    do_reset(0);
    pulse_tx();
    check("R3 awake before pin high", core_on, 1'b1);
    pin_mode = 1;
    wait_n(45);
    check("R3 pin high forces down", core_on, 1'b0);
    pulse_tx();
    check("R3 sync ignored while pin high", core_on, 1'b0);

    // R3/R4 clock stops at high while awake
    do_reset(2);
    pulse_tx(); pulse_tx();
    check("R4 clocked pin awake", core_on, 1'b1);
    pin_mode = 1;
    wait_n(45);
    check("R3 stopped clock forces down", core_on, 1'b0);
    check("R3 stopped clock drive off", pcm_drive_en, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule